// File: doc/BRIEF.md
# Gated Event Counter with Selectable Gate Source

This block is a counter that advances on a count-enable tick, but only while a gate lets it through. A two-bit select picks the gate from one of four places: an external gate pin, a one-cycle pulse from an internal 8-bit period timer, or either of two comparator result bits. The comparators are outside the block and arrive here only as digital levels. A polarity bit sets whether the chosen source is active when high or when low. A gate-enable bit can bypass the gate, and then every tick counts.

An optional toggle mode sends the polarity-adjusted gate through a flip-flop that flips on each rising edge of the gate. The counter then runs for a whole gate period rather than for one level. While toggle mode is off, the flip-flop is held clear, so the first rising edge after the mode is turned on always starts a measurement. A status output reports the effective gate level. The counter can be loaded from a write port at any time.

Top module: `gated_counter`

## Requirements
- R1: While `srst` is high at a clock edge, the counter, the period timer, the match pulse, the toggle flip-flop and the input synchronizers clear. With `gate_pol`=1, `tgl_en`=0 and all gate inputs low, `gate_val` is 0 after reset.
- R2: With `gate_en`=0, the counter adds one on every clock edge where `tick` is high, whatever the gate is.
- R3: At an edge where `tick` is low and `ld` is low, `count` keeps its value.
- R4: `src_sel`=0 selects `ext_gate`. It passes through two synchronizer flops, so a level applied from reset release takes effect at the third tick edge.
- R5: With `gate_pol`=0 the selected source gates when it is low. With `gate_pol`=1 it gates when it is high.
- R6: `src_sel`=1 selects the period-match pulse. The 8-bit period timer advances on each tick and returns to 0 on the tick where it equals `per_val`. The pulse is high from that tick until the next tick. Over N ticks from reset, polarity 1 gives floor((N-1)/(per_val+1)) counts and polarity 0 gives N minus that number.
- R7: `src_sel`=2 selects `cmp1_in` and `src_sel`=3 selects `cmp2_in`. Both are synchronized like `ext_gate`, and the inputs that are not selected have no effect.
- R8: With `tgl_en`=1, each rising edge of the polarity-adjusted gate flips the toggle flip-flop. The counter counts while the flip-flop is set and holds while it is clear.
- R9: While `tgl_en`=0, the toggle flip-flop is cleared at every edge, and the gate is the polarity-adjusted source. Turning toggle mode back on starts with the flip-flop clear.
- R10: When `ld`=1, `count` takes `ld_val` at the next edge, even if an increment is due in the same cycle.
- R11: The counter wraps from 0xFFFF to 0x0000 on an increment.
- R12: `gate_val` shows the effective gate: the toggle flip-flop when `tgl_en`=1, and otherwise the polarity-adjusted source, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| srst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Count-enable tick |
| gate_en | input | 1 | 1 = counting is gated, 0 = every tick counts |
| src_sel | input | 2 | Gate source: 0 pin, 1 period match, 2 comparator 1, 3 comparator 2 |
| gate_pol | input | 1 | 1 = source active high, 0 = active low |
| tgl_en | input | 1 | Toggle-mode enable |
| per_val | input | 8 | Period value for the match timer |
| ext_gate | input | 1 | External gate pin, asynchronous |
| cmp1_in | input | 1 | Comparator 1 result, asynchronous |
| cmp2_in | input | 1 | Comparator 2 result, asynchronous |
| ld | input | 1 | Load strobe |
| ld_val | input | 16 | Load value |
| count | output | 16 | Counter value |
| gate_val | output | 1 | Effective gate level |

## Verification
A load and a gated increment can fall due in the same cycle. The bench provokes this by pulsing `ld` while `tick` is high and the gate is bypassed. It then requires `count` to equal `ld_val` exactly and not `ld_val` plus one, and to step by one only at the next tick. A second collision happens when the toggle mode is switched off while the flip-flop is set and a gate edge could arrive. The bench judges that case by `gate_val` and by a `count` that holds still after toggle mode is turned back on.

// File: rtl/gctr_pkg.sv
package gctr_pkg;
  typedef enum logic [1:0] {
    GSRC_PIN   = 2'd0,
    GSRC_MATCH = 2'd1,
    GSRC_CMPA  = 2'd2,
    GSRC_CMPB  = 2'd3
  } gate_src_e;

  function automatic logic [15:0] f_step16(input logic [15:0] v);
    return v + 16'd1;
  endfunction

  function automatic logic f_at_period(input logic [7:0] cur, input logic [7:0] per);
    return cur == per;
  endfunction
endpackage

// File: rtl/gctr_sync.sv
module gctr_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             srst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk) begin
    if (srst) stg[0] <= '0;
    else      stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (srst) stg[i] <= '0;
      else      stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gctr_period.sv
module gctr_period #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          srst,
  input  logic          tick,
  input  logic [PW-1:0] per_val,
  output logic          match_pls
);
  logic [PW-1:0] per_cnt;
  logic          wrap_now;

  assign wrap_now = tick && (per_cnt == per_val);

  always_ff @(posedge clk) begin
    if (srst) begin
      per_cnt   <= '0;
      match_pls <= 1'b0;
    end else if (tick) begin
      match_pls <= wrap_now;
      per_cnt   <= wrap_now ? '0 : per_cnt + 1'b1;
    end
  end

  // R6
  pulse_cnt_chk: assert property (@(posedge clk) disable iff (srst)
    match_pls |-> (per_cnt == '0));

  // R6
  pulse_len_chk: assert property (@(posedge clk) disable iff (srst)
    (tick && !wrap_now) |=> !match_pls);
endmodule

// File: rtl/gctr_gate.sv
module gctr_gate
  import gctr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      srst,
  input  gate_src_e src_sel,
  input  logic      gate_pol,
  input  logic      tgl_en,
  input  logic      ext_gate,
  input  logic      cmp1_in,
  input  logic      cmp2_in,
  input  logic      match_pls,
  output logic      gate_eff
);
  localparam int NSYNC = 3;

  logic [NSYNC-1:0] raw_in, syn_in;
  logic             src_lvl, gate_adj, gate_dly, gate_rise, tff;

  assign raw_in = {cmp2_in, cmp1_in, ext_gate};

  gctr_sync #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .srst(srst),
    .d   (raw_in),
    .q   (syn_in)
  );

  always_comb begin
    unique case (src_sel)
      GSRC_PIN:   src_lvl = syn_in[0];
      GSRC_MATCH: src_lvl = match_pls;
      GSRC_CMPA:  src_lvl = syn_in[1];
      default:    src_lvl = syn_in[2];
    endcase
  end

  assign gate_adj  = gate_pol ? src_lvl : ~src_lvl;
  assign gate_rise = gate_adj & ~gate_dly;

  always_ff @(posedge clk) begin
    if (srst) begin
      gate_dly <= 1'b0;
      tff      <= 1'b0;
    end else begin
      gate_dly <= gate_adj;
      if (!tgl_en)        tff <= 1'b0;
      else if (gate_rise) tff <= ~tff;
    end
  end

  assign gate_eff = tgl_en ? tff : gate_adj;

  // R9
  tff_clr_chk: assert property (@(posedge clk) disable iff (srst)
    !tgl_en |=> !tff);

  // R8
  tff_hold_chk: assert property (@(posedge clk) disable iff (srst)
    (tgl_en && !gate_rise) |=> $stable(tff));

  // R8
  tff_flip_chk: assert property (@(posedge clk) disable iff (srst)
    (tgl_en && gate_rise) |=> (tff != $past(tff)));
endmodule

// File: rtl/gctr_counter.sv
module gctr_counter
  import gctr_pkg::*;
(
  input  logic        clk,
  input  logic        srst,
  input  logic        inc,
  input  logic        ld,
  input  logic [15:0] ld_val,
  output logic [15:0] count
);
  always_ff @(posedge clk) begin
    if (srst)     count <= '0;
    else if (ld)  count <= ld_val;
    else if (inc) count <= f_step16(count);
  end

  // R10
  ld_prio_chk: assert property (@(posedge clk) disable iff (srst)
    ld |=> (count == $past(ld_val)));

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (srst)
    (!ld && !inc) |=> $stable(count));

  // R11
  step_chk: assert property (@(posedge clk) disable iff (srst)
    (!ld && inc) |=> (count == 16'($past(count) + 16'd1)));
endmodule

// File: rtl/gated_counter.sv
module gated_counter
  import gctr_pkg::*;
#(
  parameter int PW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          srst,
  input  logic          tick,
  input  logic          gate_en,
  input  logic [1:0]    src_sel,
  input  logic          gate_pol,
  input  logic          tgl_en,
  input  logic [PW-1:0] per_val,
  input  logic          ext_gate,
  input  logic          cmp1_in,
  input  logic          cmp2_in,
  input  logic          ld,
  input  logic [15:0]   ld_val,
  output logic [15:0]   count,
  output logic          gate_val
);
  logic match_pls, gate_eff, cnt_inc;

  gctr_period #(.PW(PW)) u_per (
    .clk      (clk),
    .srst     (srst),
    .tick     (tick),
    .per_val  (per_val),
    .match_pls(match_pls)
  );

  gctr_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
    .clk      (clk),
    .srst     (srst),
    .src_sel  (gate_src_e'(src_sel)),
    .gate_pol (gate_pol),
    .tgl_en   (tgl_en),
    .ext_gate (ext_gate),
    .cmp1_in  (cmp1_in),
    .cmp2_in  (cmp2_in),
    .match_pls(match_pls),
    .gate_eff (gate_eff)
  );

  assign cnt_inc  = tick & (~gate_en | gate_eff);
  assign gate_val = gate_eff;

  gctr_counter u_cnt (
    .clk   (clk),
    .srst  (srst),
    .inc   (cnt_inc),
    .ld    (ld),
    .ld_val(ld_val),
    .count (count)
  );

  // R2
  bypass_chk: assert property (@(posedge clk) disable iff (srst)
    (tick && !gate_en && !ld) |=> (count == 16'($past(count) + 16'd1)));
endmodule

// File: tb/sim_gated_counter.sv
module sim_gated_counter;
  logic        clk = 1'b0;
  logic        srst, tick, gate_en, gate_pol, tgl_en;
  logic [1:0]  src_sel;
  logic [7:0]  per_val;
  logic        ext_gate, cmp1_in, cmp2_in, ld;
  logic [15:0] ld_val, count;
  logic        gate_val;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gated_counter u0 (
    .clk(clk), .srst(srst), .tick(tick), .gate_en(gate_en), .src_sel(src_sel),
    .gate_pol(gate_pol), .tgl_en(tgl_en), .per_val(per_val), .ext_gate(ext_gate),
    .cmp1_in(cmp1_in), .cmp2_in(cmp2_in), .ld(ld), .ld_val(ld_val),
    .count(count), .gate_val(gate_val)
  );

  typedef struct packed {
    logic [1:0]  sel;
    logic        pol;
    logic        gen;
    logic [7:0]  per;
    logic        ext;
    logic        c1;
    logic        c2;
    logic [15:0] exp;
  } vec_t;

  localparam int NT = 20;
  localparam int NV = 14;
  localparam logic [30:0] VEC [NV] = '{
    {2'd0, 1'b1, 1'b0, 8'd0,   1'b0, 1'b0, 1'b0, 16'd20}, // R2 bypass
    {2'd0, 1'b1, 1'b1, 8'd0,   1'b1, 1'b0, 1'b0, 16'd18}, // R4 pin high
    {2'd0, 1'b1, 1'b1, 8'd0,   1'b0, 1'b1, 1'b1, 16'd0},  // R4 pin low
    {2'd0, 1'b0, 1'b1, 8'd0,   1'b0, 1'b0, 1'b0, 16'd20}, // R5 active low
    {2'd0, 1'b0, 1'b1, 8'd0,   1'b1, 1'b0, 1'b0, 16'd2},  // R5 active low, pin high
    {2'd1, 1'b1, 1'b1, 8'd3,   1'b0, 1'b0, 1'b0, 16'd4},  // R6
    {2'd1, 1'b0, 1'b1, 8'd3,   1'b0, 1'b0, 1'b0, 16'd16}, // R6 inverted
    {2'd1, 1'b1, 1'b1, 8'd0,   1'b0, 1'b0, 1'b0, 16'd19}, // R6 period 0
    {2'd1, 1'b1, 1'b1, 8'd255, 1'b1, 1'b1, 1'b1, 16'd0},  // R6 long period
    {2'd2, 1'b1, 1'b1, 8'd0,   1'b0, 1'b1, 1'b0, 16'd18}, // R7 cmp1
    {2'd2, 1'b1, 1'b1, 8'd0,   1'b1, 1'b0, 1'b1, 16'd0},  // R7 others ignored
    {2'd3, 1'b1, 1'b1, 8'd0,   1'b0, 1'b0, 1'b1, 16'd18}, // R7 cmp2
    {2'd3, 1'b1, 1'b1, 8'd0,   1'b1, 1'b1, 1'b0, 16'd0},  // R7 others ignored
    {2'd1, 1'b1, 1'b1, 8'd4,   1'b0, 1'b0, 1'b0, 16'd3}   // R6 period 4
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    srst = 1'b1; tick = 1'b1;
    cyc(2);
    srst = 1'b0; tick = 1'b0;
  endtask

  task automatic pulse_ext();
    ext_gate = 1'b1;
    cyc(1);
    ext_gate = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] c0;
    srst = 1'b1; tick = 1'b0; gate_en = 1'b1; src_sel = 2'd0; gate_pol = 1'b1;
    tgl_en = 1'b0; per_val = 8'd0; ext_gate = 1'b0; cmp1_in = 1'b0; cmp2_in = 1'b0;
    ld = 1'b0; ld_val = '0;
    cyc(3);
    // R1 reset state
    do_reset();
    cyc(1);
    check(count == 16'd0, "R1 count", count, 0);
    check(gate_val == 1'b0, "R1 gate_val", gate_val, 0);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = vec_t'(VEC[i]);
      src_sel = v.sel; gate_pol = v.pol; gate_en = v.gen; per_val = v.per;
      ext_gate = v.ext; cmp1_in = v.c1; cmp2_in = v.c2; tgl_en = 1'b0;
      srst = 1'b1; tick = 1'b1;
      cyc(2);
      srst = 1'b0; tick = 1'b1;
      cyc(NT);
      tick = 1'b0;
      check(count == v.exp, $sformatf("vector %0d (R2/R4/R5/R6/R7)", i), count, v.exp);
    end

    // R3 no tick, no change
    gate_en = 1'b0; ext_gate = 1'b0; cmp1_in = 1'b0; cmp2_in = 1'b0;
    c0 = count;
    cyc(10);
    check(count == c0, "R3 idle hold", count, c0);

    // R10 load beats increment in same cycle
    tick = 1'b1; ld = 1'b1; ld_val = 16'h1234;
    cyc(1);
    ld = 1'b0; tick = 1'b0;
    check(count == 16'h1234, "R10 load priority", count, 16'h1234);
    tick = 1'b1; cyc(1); tick = 1'b0;
    check(count == 16'h1235, "R10 step after load", count, 16'h1235);

    // R11 wrap
    ld = 1'b1; ld_val = 16'hFFFF; cyc(1); ld = 1'b0;
    tick = 1'b1; cyc(1); tick = 1'b0;
    check(count == 16'h0000, "R11 wrap", count, 0);

    // R12 gate_val follows synchronized, polarity-adjusted source
    gate_en = 1'b1; src_sel = 2'd0; gate_pol = 1'b1; tgl_en = 1'b0;
    ext_gate = 1'b1;
    cyc(1);
    check(gate_val == 1'b0, "R12 sync stage 1", gate_val, 0);
    cyc(1);
    check(gate_val == 1'b1, "R12 sync stage 2", gate_val, 1);
    gate_pol = 1'b0; #1;
    check(gate_val == 1'b0, "R12 polarity flip", gate_val, 0);
    gate_pol = 1'b1; ext_gate = 1'b0;
    cyc(4);

    // R8 toggle mode measures a full period
    tgl_en = 1'b1; tick = 1'b1;
    cyc(4);
    c0 = count;
    check(gate_val == 1'b0, "R8 toggle idle", gate_val, 0);
    cyc(3);
    check(count == c0, "R8 no count before edge", count, c0);
    pulse_ext();
    cyc(3);
    check(gate_val == 1'b1, "R8 toggle set", gate_val, 1);
    c0 = count;
    cyc(10);
    check(count == 16'(c0 + 16'd10), "R8 counts while set", count, c0 + 10);
    pulse_ext();
    cyc(3);
    check(gate_val == 1'b0, "R8 toggle clear", gate_val, 0);
    c0 = count;
    cyc(5);
    check(count == c0, "R8 holds while clear", count, c0);

    // R9 disabling toggle clears the flip-flop
    pulse_ext();
    cyc(3);
    check(gate_val == 1'b1, "R9 toggle set again", gate_val, 1);
    tgl_en = 1'b0; #1;
    check(gate_val == 1'b0, "R9 direct gate when off", gate_val, 0);
    cyc(2);
    tgl_en = 1'b1;
    cyc(1);
    c0 = count;
    check(gate_val == 1'b0, "R9 restart clear", gate_val, 0);
    cyc(5);
    check(count == c0, "R9 no count after restart", count, c0);
    tick = 1'b0;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule